// File: doc/BRIEF.md
# Integer Execute Unit With Division

This unit performs the arithmetic of a small signed register machine whose values are 32-bit two's-complement integers. It takes operand A, a second operand and an operation code, and it returns a result. The second operand is either a register value or a 16-bit immediate, sign-extended to the full width. All operations except divide and remainder are combinational: the result follows the inputs in the same cycle. Overflow in any of them wraps silently.

Divide and remainder run on an iterative unit, one quotient bit per clock. A one-cycle start pulse captures the operands. The unit is busy while it works and gives a one-cycle done pulse at the end. The result and the error flag are then held until the next accepted start.

The quotient rounds toward negative infinity. The remainder is the truncating remainder, so its sign follows the dividend. A zero divisor raises the error flag and gives no value.

Top module: `int_exec_unit`

## Requirements
- R1: Operation codes are ADD=0, SUB=1 and MUL=2. Each returns the low 32 bits of A+B, A-B or A*B, wrapping in two's complement with no error.
- R2: When use_imm_i is 1, the second operand B is imm_i sign-extended from 16 to 32 bits. When use_imm_i is 0, B is b_i.
- R3: Operation code SLT=5 returns 1 when A < B as signed values, and 0 otherwise.
- R4: Operation codes AND=6, OR=7 and XOR=8 are bitwise on A and B. NOT=9 returns the inverse of every bit of A.
- R5: The shift codes are SLL=10 (zero fill), SRL=11 (zero fill from the top) and SRA=12 (copies of the sign bit fill from the top). A is shifted by the low 5 bits of B only.
- R6: Operation code DIV=3, started with start_i, gives the floor of A/B as a signed quotient.
- R7: Operation code REM=4, started with start_i, gives the truncating remainder of A/B, whose sign matches A (or is zero).
- R8: A divide or remainder with B=0 ends with err_o=1 and result_o=0. done_o is high in the cycle after the first clock edge that follows the edge capturing the start.
- R9: The most negative value divided by -1 gives the most negative value with err_o=0, and the matching remainder is 0.
- R10: For a nonzero divisor, done_o is high for exactly one cycle. That cycle follows the 33rd rising edge after the edge that captured start_i. busy_o is high from the capture until done_o rises.
- R11: While op_i is DIV or REM, result_o shows the held result of the last completed divide. That result does not change until a new start is accepted. A start while busy_o is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 4 | Operation code |
| a_i | input | 32 | Operand A |
| b_i | input | 32 | Register operand B |
| imm_i | input | 16 | Immediate operand, sign-extended when selected |
| use_imm_i | input | 1 | Selects the immediate as operand B |
| start_i | input | 1 | Starts a divide or remainder |
| busy_o | output | 1 | Divide in progress |
| done_o | output | 1 | One-cycle pulse when a divide finishes |
| result_o | output | 32 | Result |
| err_o | output | 1 | Last divide had a zero divisor |

## Verification
Random operands for all combinational codes, with the register operand and the immediate selected in turn, check wrapping, sign handling and shift-amount masking against bench reference functions. Divides cover the four sign combinations with and without a remainder, and an exact negative quotient. These separate floor rounding from truncation, and a dividend-signed remainder from a divisor-signed one. The most-negative-by-minus-one case and a zero divisor test the wrap and the error path. Further tests check done timing for nonzero and zero divisors, a start pulse sent in mid-run, and a held result under changing operands.

// File: rtl/int_exec_unit.sv
module int_exec_unit #(
  parameter int WIDTH = 32,
  parameter int IMM_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic             use_imm_i,
  input  logic             start_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [WIDTH-1:0] result_o,
  output logic             err_o
);
  localparam int SH_W  = $clog2(WIDTH);
  localparam int CNT_W = $clog2(WIDTH);
  localparam logic [3:0] OP_ADD = 4'd0, OP_SUB = 4'd1, OP_MUL = 4'd2,
                         OP_DIV = 4'd3, OP_REM = 4'd4, OP_SLT = 4'd5,
                         OP_AND = 4'd6, OP_OR  = 4'd7, OP_XOR = 4'd8,
                         OP_NOT = 4'd9, OP_SLL = 4'd10, OP_SRL = 4'd11,
                         OP_SRA = 4'd12;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} st_t;

  logic [WIDTH-1:0] opb;
  logic [SH_W-1:0]  shamt;
  logic [WIDTH-1:0] comb_res;
  logic             is_div_op;

  assign opb       = use_imm_i ? {{(WIDTH-IMM_W){imm_i[IMM_W-1]}}, imm_i} : b_i;
  assign shamt     = opb[SH_W-1:0];
  assign is_div_op = (op_i == OP_DIV) || (op_i == OP_REM);

  always_comb begin
    case (op_i)
      OP_ADD:  comb_res = a_i + opb;
      OP_SUB:  comb_res = a_i - opb;
      OP_MUL:  comb_res = a_i * opb;
      OP_SLT:  comb_res = {{(WIDTH-1){1'b0}}, ($signed(a_i) < $signed(opb))};
      OP_AND:  comb_res = a_i & opb;
      OP_OR:   comb_res = a_i | opb;
      OP_XOR:  comb_res = a_i ^ opb;
      OP_NOT:  comb_res = ~a_i;
      OP_SLL:  comb_res = a_i << shamt;
      OP_SRL:  comb_res = a_i >> shamt;
      OP_SRA:  comb_res = $signed(a_i) >>> shamt;
      default: comb_res = '0;
    endcase
  end

  st_t              st;
  logic [CNT_W-1:0] cnt;
  logic [WIDTH-1:0] quot, rem, dvsr, res_q;
  logic             a_neg, b_neg, rem_sel, zero_div, err_q, done_q;

  logic [WIDTH-1:0] amag, bmag;
  assign amag = a_i[WIDTH-1] ? (~a_i + 1'b1) : a_i;
  assign bmag = opb[WIDTH-1] ? (~opb + 1'b1) : opb;

  logic [WIDTH:0]   shifted;
  logic [WIDTH-1:0] sub;
  logic             fits;
  assign shifted = {rem, quot[WIDTH-1]};
  assign fits    = shifted >= {1'b0, dvsr};
  assign sub     = shifted[WIDTH-1:0] - dvsr;

  logic             q_neg;
  logic [WIDTH-1:0] q_trunc, r_trunc, q_floor, fin_val;
  assign q_neg   = a_neg ^ b_neg;
  assign q_trunc = q_neg ? (~quot + 1'b1) : quot;
  assign r_trunc = a_neg ? (~rem + 1'b1) : rem;
  assign q_floor = q_trunc - {{(WIDTH-1){1'b0}}, (q_neg && (rem != '0))};
  assign fin_val = zero_div ? '0 : (rem_sel ? r_trunc : q_floor);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      quot     <= '0;
      rem      <= '0;
      dvsr     <= '0;
      res_q    <= '0;
      a_neg    <= 1'b0;
      b_neg    <= 1'b0;
      rem_sel  <= 1'b0;
      zero_div <= 1'b0;
      err_q    <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (start_i && is_div_op) begin
          quot     <= amag;
          rem      <= '0;
          dvsr     <= bmag;
          a_neg    <= a_i[WIDTH-1];
          b_neg    <= opb[WIDTH-1];
          rem_sel  <= (op_i == OP_REM);
          zero_div <= (opb == '0);
          cnt      <= '0;
          st       <= (opb == '0) ? S_FIN : S_RUN;
        end
        S_RUN: begin
          quot <= {quot[WIDTH-2:0], fits};
          rem  <= fits ? sub : shifted[WIDTH-1:0];
          cnt  <= cnt + 1'b1;
          if (cnt == CNT_W'(WIDTH-1)) st <= S_FIN;
        end
        S_FIN: begin
          res_q  <= fin_val;
          err_q  <= zero_div;
          done_q <= 1'b1;
          st     <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy_o   = (st != S_IDLE);
  assign done_o   = done_q;
  assign err_o    = err_q;
  assign result_o = is_div_op ? res_q : comb_res;
endmodule

// File: rtl/int_exec_unit_chk.sv
module int_exec_unit_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [3:0]       op_i,
  input logic [WIDTH-1:0] a_i,
  input logic             start_i,
  input logic             busy_o,
  input logic             done_o,
  input logic [WIDTH-1:0] result_o,
  input logic             err_o,
  input logic [WIDTH-1:0] res_q
);
  logic div_op;
  assign div_op = (op_i == 4'd3) || (op_i == 4'd4);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  assert_start_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && div_op) |=> busy_o);

  assert_err_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (err_o && div_op) |-> (result_o == '0));

  assert_slt_bool_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 4'd5) |-> (result_o[WIDTH-1:1] == '0));

  assert_not_inv_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 4'd9) |-> ((result_o ^ a_i) == '1));

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> $stable(res_q));
endmodule

bind int_exec_unit int_exec_unit_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_i(op_i), .a_i(a_i), .start_i(start_i),
  .busy_o(busy_o), .done_o(done_o), .result_o(result_o), .err_o(err_o),
  .res_q(res_q)
);

// File: tb/int_exec_unit_test.sv
module int_exec_unit_test;
  logic        clk, rst_n;
  logic [3:0]  op_i;
  logic [31:0] a_i, b_i;
  logic [15:0] imm_i;
  logic        use_imm_i, start_i;
  logic        busy_o, done_o, err_o;
  logic [31:0] result_o;

  int checks = 0;
  int errors = 0;

  int_exec_unit uut (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .a_i(a_i), .b_i(b_i),
    .imm_i(imm_i), .use_imm_i(use_imm_i), .start_i(start_i),
    .busy_o(busy_o), .done_o(done_o), .result_o(result_o), .err_o(err_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish (actual hung, expected finish)");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] sext(logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  function automatic logic [31:0] ref_alu(logic [3:0] op, logic [31:0] a, logic [31:0] b);
    case (op)
      4'd0:    return a + b;
      4'd1:    return a - b;
      4'd2:    return a * b;
      4'd5:    return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      4'd6:    return a & b;
      4'd7:    return a | b;
      4'd8:    return a ^ b;
      4'd9:    return ~a;
      4'd10:   return a << b[4:0];
      4'd11:   return a >> b[4:0];
      4'd12:   return $signed(a) >>> b[4:0];
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic [31:0] ref_div(bit want_rem, logic [31:0] a, logic [31:0] b);
    int sa, sb, q, r;
    sa = a; sb = b;
    if (sb == 0) return 32'd0;
    if (sb == -1) return want_rem ? 32'd0 : (32'd0 - a);
    q = sa / sb;
    r = sa % sb;
    if (r != 0 && ((sa < 0) != (sb < 0))) q = q - 1;
    return want_rem ? r : q;
  endfunction

  task automatic alu_chk(string req, logic [3:0] op, logic [31:0] a, logic [31:0] b,
                         logic [15:0] imm, bit ui);
    @(negedge clk);
    op_i = op; a_i = a; b_i = b; imm_i = imm; use_imm_i = ui;
    #2;
    chk(req, result_o, ref_alu(op, a, ui ? sext(imm) : b));
  endtask

  task automatic div_chk(string req, bit want_rem, logic [31:0] a, logic [31:0] b);
    int n;
    @(negedge clk);
    op_i = want_rem ? 4'd4 : 4'd3; a_i = a; b_i = b; use_imm_i = 1'b0; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    n = 1;
    while (!done_o && n < 200) begin
      @(negedge clk);
      n++;
    end
    chk({req, " timing R10"}, n, (b == 32'd0) ? 32'd2 : 32'd34);
    chk({req, " value"}, result_o, ref_div(want_rem, a, b));
    chk({req, " err R8"}, {31'd0, err_o}, {31'd0, (b == 32'd0)});
  endtask

  initial begin
    rst_n = 1'b0; op_i = 4'd3; a_i = '0; b_i = '0; imm_i = '0;
    use_imm_i = 1'b0; start_i = 1'b0;
    void'($urandom(32'd5171));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("reset busy R10", {31'd0, busy_o}, 32'd0);
    chk("reset done R10", {31'd0, done_o}, 32'd0);
    chk("reset err R8", {31'd0, err_o}, 32'd0);
    chk("reset result R11", result_o, 32'd0);

    // directed combinational corners
    alu_chk("R1 add wrap", 4'd0, 32'h7fffffff, 32'd1, 16'd0, 1'b0);
    alu_chk("R1 sub wrap", 4'd1, 32'h80000000, 32'd1, 16'd0, 1'b0);
    alu_chk("R1 mul low", 4'd2, 32'h00012345, 32'h00054321, 16'd0, 1'b0);
    alu_chk("R2 imm sext", 4'd0, 32'd10, 32'd99, 16'hffff, 1'b1);
    alu_chk("R2 imm pos", 4'd7, 32'd0, 32'd99, 16'h7abc, 1'b1);
    alu_chk("R3 slt neg", 4'd5, 32'hffffffff, 32'd0, 16'd0, 1'b0);
    alu_chk("R3 slt eq", 4'd5, 32'd5, 32'd5, 16'd0, 1'b0);
    alu_chk("R4 not", 4'd9, 32'h0f0f1234, 32'd0, 16'd0, 1'b0);
    alu_chk("R4 xor", 4'd8, 32'hdeadbeef, 32'h12345678, 16'd0, 1'b0);
    alu_chk("R5 sll mask", 4'd10, 32'h00000003, 32'd33, 16'd0, 1'b0);
    alu_chk("R5 srl", 4'd11, 32'h80000000, 32'd4, 16'd0, 1'b0);
    alu_chk("R5 sra", 4'd12, 32'h80000000, 32'd4, 16'd0, 1'b0);
    alu_chk("R5 sra imm", 4'd12, 32'hf0000000, 32'd0, 16'h0023, 1'b1);

    // random combinational
    for (int i = 0; i < 300; i++) begin
      logic [3:0] op;
      op = 4'($urandom_range(0, 12));
      if (op == 4'd3 || op == 4'd4) op = 4'd0;
      alu_chk("R1-5 random", op, $urandom, $urandom, 16'($urandom), 1'($urandom));
    end

    // directed divides
    div_chk("R6 pos/pos", 1'b0, 32'd7, 32'd2);
    div_chk("R6 neg/pos floor", 1'b0, -32'd7, 32'd2);
    div_chk("R6 pos/neg floor", 1'b0, 32'd7, -32'd2);
    div_chk("R6 neg/neg", 1'b0, -32'd7, -32'd2);
    div_chk("R6 exact neg", 1'b0, -32'd8, 32'd2);
    div_chk("R7 rem neg dividend", 1'b1, -32'd7, 32'd2);
    div_chk("R7 rem neg divisor", 1'b1, 32'd7, -32'd2);
    div_chk("R7 rem neg/neg", 1'b1, -32'd7, -32'd2);
    div_chk("R9 min/-1 quotient", 1'b0, 32'h80000000, 32'hffffffff);
    div_chk("R9 min/-1 rem", 1'b1, 32'h80000000, 32'hffffffff);
    div_chk("R8 div by zero", 1'b0, 32'd55, 32'd0);
    div_chk("R8 rem by zero", 1'b1, -32'd55, 32'd0);
    div_chk("R6 min/1", 1'b0, 32'h80000000, 32'd1);

    // random divides
    for (int i = 0; i < 60; i++) begin
      logic [31:0] a, b;
      a = $urandom;
      b = (i % 3 == 0) ? 32'($signed(16'($urandom))) : $urandom;
      if (b == 32'd0) b = 32'd3;
      div_chk((i % 2) ? "R7 random rem" : "R6 random div", 1'(i % 2), a, b);
    end

    // R11: start while busy is ignored
    begin
      int n;
      @(negedge clk);
      op_i = 4'd3; a_i = 32'd100; b_i = 32'd7; use_imm_i = 1'b0; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      n = 1;
      repeat (5) begin @(negedge clk); n++; end
      a_i = 32'd1; b_i = 32'd1; start_i = 1'b1;
      @(negedge clk); n++;
      start_i = 1'b0;
      while (!done_o && n < 200) begin @(negedge clk); n++; end
      chk("R11 busy start ignored timing", n, 32'd34);
      chk("R11 busy start ignored value", result_o, 32'd14);
    end

    // R11: held result under changing operands and op switch
    @(negedge clk);
    op_i = 4'd4; a_i = 32'h12345678; b_i = 32'd9;
    repeat (5) @(negedge clk);
    chk("R11 held result", result_o, 32'd14);
    chk("R11 done low after pulse", {31'd0, done_o}, 32'd0);

    repeat (2) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule